// File: doc/BRIEF.md
# Register-Access Frame Engine

This block lets on-chip logic read and write single registers in an external SPI peripheral. Each access uses one fixed 24-bit frame. A requester presents a read/write flag, a 6-bit register address and 16 bits of write data. The engine builds the frame and works out its parity bit. It then generates the serial clock and drives an active-low chip select, which stays asserted for the whole frame. It shifts the frame out and collects the 24 bits the peripheral returns. Those bits come back as one word, together with a one-cycle completion strobe.

The serial clock runs in mode 0. It idles low, outgoing data changes after each falling edge, and incoming data is sampled at each rising edge. The SCLK half period, in system clocks, is set by an input. A second input sets the minimum time chip select must stay high between frames. With a 32 MHz system clock, values from 13 (about 400 ns) to 32 (1 us) match typical peripheral needs. The engine counts that gap from reset as well, so the first frame after power-up is also preceded by a proper idle period. A ready signal holds off new requests until the engine is idle and the gap has elapsed.

Top module: `spi_reg_frame_engine`

## Requirements
- R1: The frame is shifted out on `pico` MSB first. Its layout is: bit 23 is the access flag (1 = read), bits 22:17 are the register address, bit 16 is parity, and bits 15:0 are the write data.
- R2: The parity bit makes the number of ones in the full 24-bit frame even. A read of address 0 with data 0 therefore encodes as 0x810000.
- R3: Once a frame starts, `cs_n` stays low without release until all 24 bits have been clocked. `cs_n` falls exactly once per frame.
- R4: Each frame has exactly 24 rising `sclk` edges, all while `cs_n` is low. `sclk` is low whenever `cs_n` is high.
- R5: `poci` is sampled at each rising `sclk` edge. The 24 samples are assembled MSB first (first sample in bit 23) into `rsp_data`.
- R6: `rsp_valid` pulses for exactly one cycle. That cycle is the first one in which `cs_n` is high again after a frame. `rsp_data` then holds its value until the next frame completes.
- R7: `cs_n` is high during and after reset. Before every frame, including the first after reset, `cs_n` has been high for at least `cfg_gap` system clocks.
- R8: `req_ready` is high only when no frame is in progress and the gap of R7 has elapsed. A request made while `req_ready` is low is ignored and starts no frame.
- R9: Each `sclk` high and low phase lasts `cfg_half` system clocks. A value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | 8 | SCLK half period in system clocks (0 acts as 1) |
| cfg_gap | input | 6 | Minimum chip-select high time in system clocks |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Engine idle and inter-frame gap elapsed |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_addr | input | 6 | Register address |
| req_wdata | input | 16 | Data field of the frame |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | 24 | Word sampled from poci, MSB first |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| pico | output | 1 | Serial data to the peripheral |
| poci | input | 1 | Serial data from the peripheral |

## Verification
The hardest case to reach from the ports is a request held on `req_valid` across a whole frame and into the completion cycle. At that point the engine is idle but the gap has not elapsed, so a wrong ready term would start a frame with almost no chip-select high time. The bench keeps a conflicting request asserted from inside a frame through `rsp_valid`. It then confirms that no second `cs_n` fall occurs and that the captured `pico` word still belongs to the first request. The vector table runs its frames back to back so that every frame starts at the earliest allowed cycle. The idle time is measured on `cs_n` each time, starting with the first frame after reset.

// File: rtl/sef_pkg.sv
package sef_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W + 2;

  // Field order inside the frame is fixed by the peripheral decoding it.
  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic              par;
    logic [DATA_W-1:0] data;
  } frame_t;

  // Build a frame whose total count of ones is even.
  function automatic frame_t make_frame(input logic rd,
                                        input logic [ADDR_W-1:0] addr,
                                        input logic [DATA_W-1:0] data);
    frame_t f;
    f.rd   = rd;
    f.addr = addr;
    f.data = data;
    f.par  = 1'b0;
    f.par  = ^f;
    return f;
  endfunction
endpackage

// File: rtl/sef_gap_timer.sv
module sef_gap_timer #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [GAP_W-1:0] gap_min,
  output logic             gap_ok
);
  logic [GAP_W-1:0] hi_cnt;

  // Counts cycles with chip select high, saturating; restarts at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= '0;
    else if (!cs_n)          hi_cnt <= '0;
    else if (hi_cnt != '1)   hi_cnt <= hi_cnt + GAP_W'(1);
  end

  assign gap_ok = cs_n && (hi_cnt >= gap_min);
endmodule

// File: rtl/sef_shifter.sv
module sef_shifter
  import sef_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  frame_t             frame,
  input  logic [DIV_W-1:0]   half_per,
  input  logic               poci,
  output logic               sclk,
  output logic               pico,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [DIV_W-1:0]   div_cnt;
  logic [DIV_W-1:0]   half_eff;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;
  logic               tick, rise_evt, fall_evt, last_fall;

  assign half_eff  = (half_per == '0) ? DIV_W'(1) : half_per;
  assign tick      = busy && (div_cnt == half_eff - DIV_W'(1));
  assign rise_evt  = tick && !sclk;
  assign fall_evt  = tick && sclk;
  assign last_fall = fall_evt && (bit_cnt == CNT_W'(FRAME_W));
  assign pico      = tx_sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
    end else begin
      done <= last_fall;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          sclk    <= 1'b0;
          div_cnt <= '0;
          bit_cnt <= '0;
          tx_sh   <= frame;
        end
      end else if (tick) begin
        div_cnt <= '0;
        sclk    <= ~sclk;
        if (rise_evt) begin
          rx_sh   <= {rx_sh[FRAME_W-2:0], poci};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end else if (last_fall) begin
          busy    <= 1'b0;
          rx_word <= rx_sh;
        end else begin
          tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  // R2: every frame loaded for shifting has even parity
  p_parity_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !(^tx_sh));

  // R4: no rising edge beyond the last frame bit
  p_edge_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (bit_cnt < CNT_W'(FRAME_W)));

  // R4: clock idles low outside a frame
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
endmodule

// File: rtl/spi_reg_frame_engine.sv
module spi_reg_frame_engine
  import sef_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_half,
  input  logic [GAP_W-1:0]   cfg_gap,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_read,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [FRAME_W-1:0] rsp_data,
  output logic               sclk,
  output logic               cs_n,
  output logic               pico,
  input  logic               poci
);
  logic   busy, gap_ok, start;
  frame_t frame;

  assign frame     = make_frame(req_read, req_addr, req_wdata);
  assign cs_n      = ~busy;
  assign req_ready = !busy && gap_ok;
  assign start     = req_valid && req_ready;

  sef_gap_timer #(.GAP_W(GAP_W)) i_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .gap_min (cfg_gap),
    .gap_ok  (gap_ok)
  );

  sef_shifter #(.DIV_W(DIV_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .frame    (frame),
    .half_per (cfg_half),
    .poci     (poci),
    .sclk     (sclk),
    .pico     (pico),
    .busy     (busy),
    .done     (rsp_valid),
    .rx_word  (rsp_data)
  );

  // Independent measure of chip-select high time for the gap check.
  logic [GAP_W-1:0] cs_hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cs_hi_len <= '0;
    else if (!cs_n)             cs_hi_len <= '0;
    else if (cs_hi_len != '1)   cs_hi_len <= cs_hi_len + GAP_W'(1);
  end

  // R7: chip select was high long enough before each frame
  p_min_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (cs_hi_len >= cfg_gap));

  // R8: an accepted request starts a frame on the next cycle
  p_accept_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !cs_n);

  // R8: no readiness while a frame is in flight
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R3: clock activity only under an asserted chip select
  p_sclk_under_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R6: completion coincides with chip select returning high
  p_done_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(cs_n));

  // R6: completion strobe lasts one cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/test_spi_reg_frame_engine.sv
`timescale 1ns/1ps
module test_spi_reg_frame_engine;
  localparam int CLK_NS = 4;

  typedef struct packed {
    logic        rd;
    logic [5:0]  addr;
    logic [15:0] wd;
    logic [23:0] resp;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h00, 16'h0000, 24'hA5C3F0, 24'h810000},
    '{1'b0, 6'h01, 16'h0000, 24'h000001, 24'h030000},
    '{1'b1, 6'h3F, 16'hFFFF, 24'h800000, 24'hFFFFFF},
    '{1'b0, 6'h15, 16'h00FF, 24'h5A5A5A, 24'h2B00FF},
    '{1'b1, 6'h2A, 16'h1234, 24'hFFFFFF, 24'hD51234},
    '{1'b0, 6'h00, 16'h8001, 24'h123456, 24'h008001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half = 8'd2;
  logic [5:0]  cfg_gap = 6'd13;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_read = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [23:0] rsp_data;
  logic        sclk, cs_n, pico;
  logic        poci = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  spi_reg_frame_engine i_spi_reg_frame_engine (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .sclk(sclk), .cs_n(cs_n), .pico(pico), .poci(poci)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Peripheral model and line monitors
  logic [23:0] slave_resp = '0;
  logic [23:0] cap_pico = '0;
  int idx = 0, rises = 0, stray = 0, falls = 0;
  longint t_hi = 0, gap_ns = 0, t_sr = 0, hi_ns = 0;

  always @(posedge rst_n) t_hi = $time;
  always @(posedge cs_n) if (rst_n) t_hi = $time;
  always @(negedge cs_n) begin
    idx = 23; poci = slave_resp[23]; rises = 0; falls++;
    gap_ns = $time - t_hi;
  end
  always @(negedge sclk) begin
    hi_ns = $time - t_sr;
    if (!cs_n) begin
      idx--;
      if (idx >= 0) poci = slave_resp[idx];
    end
  end
  always @(posedge sclk) begin
    t_sr = $time;
    if (cs_n) stray++;
    rises++;
    cap_pico = {cap_pico[22:0], pico};
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_ge(input string req, input longint act, input longint lim);
    checks++;
    if (act < lim) begin
      failures++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  function automatic int ones24(input logic [23:0] w);
    int n = 0;
    for (int b = 0; b < 24; b++) if (w[b]) n++;
    return n;
  endfunction

  task automatic issue(input logic rd, input logic [5:0] a, input logic [15:0] d);
    while (!req_ready) @(negedge clk);
    req_read = rd; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!rsp_valid) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    int fcount;
    repeat (3) @(negedge clk);
    // Reset state
    check("R7 cs_n high in reset", cs_n, 1);
    check("R4 sclk low in reset", sclk, 0);
    check("R6 rsp_valid low in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 not ready before gap after reset", req_ready, 0);

    // Table of vectors, frames back to back
    for (int i = 0; i < NV; i++) begin
      slave_resp = VECS[i].resp;
      issue(VECS[i].rd, VECS[i].addr, VECS[i].wd);
      wait_done();
      check("R6 cs_n high at done", cs_n, 1);
      check("R5 response word", rsp_data, VECS[i].resp);
      check("R1 frame on pico", cap_pico, VECS[i].exp);
      check("R2 even ones", 32'(ones24(cap_pico) % 2), 0);
      check("R4 rising edges per frame", rises, 24);
      check("R3 one cs fall per frame", falls, i + 1);
      check_ge("R7 cs high gap ns", gap_ns, 13 * CLK_NS);
      check("R9 sclk high width ns", 32'(hi_ns), 2 * CLK_NS);
      @(negedge clk);
      check("R6 single-cycle done", rsp_valid, 0);
    end

    // Request held during a frame and through completion is ignored
    slave_resp = 24'h0F0F0F;
    fcount = falls;
    issue(1'b1, 6'h00, 16'h0000);
    repeat (4) @(negedge clk);
    check("R8 not ready while busy", req_ready, 0);
    req_read = 1'b0; req_addr = 6'h3F; req_wdata = 16'hFFFF; req_valid = 1'b1;
    wait_done();
    req_valid = 1'b0;
    held = rsp_data;
    repeat (40) @(negedge clk);
    check("R8 ignored request started no frame", falls, fcount + 1);
    check("R1 first request kept", cap_pico, 24'h810000);
    check("R6 rsp_data held", rsp_data, held);
    check("R5 response of held test", held, 24'h0F0F0F);

    // Divider settings
    cfg_half = 8'd5;
    slave_resp = 24'hC00003;
    issue(1'b0, 6'h2A, 16'hFFFF);
    wait_done();
    check("R9 half period 5", 32'(hi_ns), 5 * CLK_NS);
    check("R5 response at half 5", rsp_data, 24'hC00003);
    check("R4 edges at half 5", rises, 24);
    cfg_half = 8'd0;
    cfg_gap = 6'd32;
    slave_resp = 24'h7FFFFE;
    issue(1'b1, 6'h01, 16'h0001);
    wait_done();
    check("R9 half period 0 acts as 1", 32'(hi_ns), 1 * CLK_NS);
    check("R5 response at half 0", rsp_data, 24'h7FFFFE);
    check_ge("R7 gap of 32", gap_ns, 32 * CLK_NS);
    issue(1'b0, 6'h00, 16'h0000);
    wait_done();
    check_ge("R7 back to back gap of 32", gap_ns, 32 * CLK_NS);
    check("R2 all-zero write frame", cap_pico, 24'h000000);
    check("R4 no edges outside cs", stray, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule